// File: doc/BRIEF.md
# Random Generator Register and Interrupt Controller

This block is the software-facing front of a hardware random number generator. A register bus carries single-cycle 32-bit reads and writes at five word offsets. Through them software starts a self-test or a seed operation, masks the two interrupt causes, reads status and error codes, and drains random words from a 16-entry output FIFO. A 32-bit xorshift generator stands in for the entropy source. An external health flag stands in for the source's statistical check and is sampled when a seed operation completes.

Each operation runs for `OP_CYCLES` clock cycles. When a seed operation ends cleanly, the FIFO is refilled with one generator word per cycle until it is full again. Reads return data in the same cycle: `reg_rdata` is combinational from `reg_addr` while `reg_rd` is high. A FIFO read pops the word at the clock edge that ends the access. The FIFO port has no back-pressure: software consults the fill level first. An empty read is flagged as an error and is never stalled.

Top module: `rng_ctrl_regs`

## Requirements
- R1: Registers decode at byte offsets 0x04 command, 0x08 control, 0x0C status, 0x10 error and 0x14 FIFO. A read of any other offset returns 0, and a write to it changes nothing. The command register always reads 0.
- R2: Control bit 5 masks the done interrupt and control bit 6 masks the error interrupt. Control resets to 0x60 and reads back only those two bits.
- R3: Writing command bit 0 starts a self-test. After `OP_CYCLES` cycles, status bit 4 (self-test done) is set.
- R4: Writing command bit 1 starts a seed operation. After `OP_CYCLES` cycles, status bit 5 (seed done) is set. If bits 0 and 1 are written together, only the seed operation runs.
- R5: A start command written while an operation is running is ignored.
- R6: If the health flag is high when a seed operation completes, the error register becomes 0x8, status bit 16 is set and the FIFO is not refilled. A later seed may be started.
- R7: After a clean seed completes, the FIFO fills with successive xorshift32 words (x^=x<<13; x^=x>>17; x^=x<<5), starting from state 0x2545F491 after reset. Status bits 11:8 show the fill level, and a full FIFO of 16 words reads as 0xF.
- R8: Each FIFO read returns the oldest word and pops it. A read of an empty FIFO returns 0 and sets error bit 0 (0x1) together with status bit 16.
- R9: Command bit 4 clears both done bits, but only while the error register is zero.
- R10: Command bit 5 clears the error register and both done bits.
- R11: `irq` is high when a done bit is set with the done mask clear, or when the error register is nonzero with the error mask clear.
- R12: The health flag is ignored outside the cycle in which a seed operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle that `reg_rd` is high |
| health_fail | input | 1 | Statistical fault flag from the entropy source |
| irq | output | 1 | Interrupt request, level sensitive |

## Verification
The bench writes a start command while another operation is running. A design that restarted would set the wrong done bit or show a level above zero. It also issues the clear-interrupt command while an error is pending. A design that ignored the error gate would drop the status and the interrupt early. It drains the FIFO after a failed seed down to an empty read. Refill after the failure, a nonzero empty read, or a lost underflow code would each show up as a wrong word or a wrong error value. Random reads, mask writes and unmapped writes follow the generator sequence across many refill and pop overlaps. A design that reordered or dropped a word would break that sequence.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_ERR  = 8'h10;
  localparam logic [7:0] OFS_FIFO = 8'h14;

  localparam int CMD_TEST   = 0;
  localparam int CMD_SEED   = 1;
  localparam int CMD_CLRINT = 4;
  localparam int CMD_CLRERR = 5;
  localparam int CTL_MDONE  = 5;
  localparam int CTL_MERR   = 6;
  localparam int ST_TDONE   = 4;
  localparam int ST_SDONE   = 5;
  localparam int ST_LVL_LO  = 8;
  localparam int ST_ERR     = 16;
  localparam int ERR_UNDER  = 0;
  localparam int ERR_STAT   = 3;

  typedef enum logic [1:0] {OP_IDLE, OP_TEST, OP_SEED} op_e;

  function automatic logic [31:0] xs_next(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction
endpackage

// File: rtl/rngc_xorshift.sv
module rngc_xorshift #(
  parameter logic [31:0] INIT = 32'h2545F491
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [31:0] word
);
  import rngc_pkg::*;
  logic [31:0] state;

  assign word = xs_next(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= INIT;
    else if (step) state <= word;
  end

  assert_nonzero_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != 32'h0);
endmodule

// File: rtl/rngc_fifo.sv
module rngc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign dout = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; count <= '0;
    end else begin
      if (push) wp <= inc(wp);
      if (pop)  rp <= inc(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH)));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/rngc_opseq.sv
module rngc_opseq #(
  parameter int OP_CYCLES = 8,
  localparam int CW = $clog2(OP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_test,
  input  logic start_seed,
  output logic busy,
  output logic done_test,
  output logic done_seed
);
  import rngc_pkg::*;
  op_e         op;
  logic [CW-1:0] cnt;

  assign busy      = (op != OP_IDLE);
  assign done_test = (op == OP_TEST) && (cnt == '0);
  assign done_seed = (op == OP_SEED) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_IDLE; cnt <= '0;
    end else if (op == OP_IDLE) begin
      if (start_seed) begin
        op <= OP_SEED; cnt <= CW'(OP_CYCLES - 1);
      end else if (start_test) begin
        op <= OP_TEST; cnt <= CW'(OP_CYCLES - 1);
      end
    end else if (cnt == '0) begin
      op <= OP_IDLE;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1 && op == $past(op)));
  assert_single_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_test, done_seed}));
endmodule

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs #(
  parameter int          OP_CYCLES = 8,
  parameter int          DEPTH     = 16,
  parameter logic [31:0] GEN_INIT  = 32'h2545F491,
  localparam int         CW        = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        health_fail,
  output logic        irq
);
  import rngc_pkg::*;

  logic          busy, done_test, done_seed;
  logic          tdone, sdone, mask_done, mask_err, seeded;
  logic [3:0]    err;
  logic [CW-1:0] level;
  logic [31:0]   gen_word, fifo_head, status;
  logic [3:0]    lvl_field;
  logic          wr_cmd, wr_ctrl, rd_fifo, push, pop, under, stat_fail;
  logic          clr_int_ok, clr_err, seed_go;

  assign wr_cmd     = reg_wr && (reg_addr == OFS_CMD);
  assign wr_ctrl    = reg_wr && (reg_addr == OFS_CTRL);
  assign rd_fifo    = reg_rd && (reg_addr == OFS_FIFO);
  assign clr_err    = wr_cmd && reg_wdata[CMD_CLRERR];
  assign clr_int_ok = wr_cmd && reg_wdata[CMD_CLRINT] && (err == '0);
  assign seed_go    = wr_cmd && reg_wdata[CMD_SEED] && !busy;
  assign pop        = rd_fifo && (level != '0);
  assign under      = rd_fifo && (level == '0);
  assign push       = seeded && (level < CW'(DEPTH));
  assign stat_fail  = done_seed && health_fail;

  rngc_opseq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_test(wr_cmd && reg_wdata[CMD_TEST]),
    .start_seed(wr_cmd && reg_wdata[CMD_SEED]),
    .busy(busy), .done_test(done_test), .done_seed(done_seed)
  );

  rngc_xorshift #(.INIT(GEN_INIT)) u_gen (
    .clk(clk), .rst_n(rst_n), .step(push), .word(gen_word)
  );

  rngc_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(gen_word),
    .pop(pop), .dout(fifo_head), .count(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdone <= 1'b0; sdone <= 1'b0; err <= '0; seeded <= 1'b0;
      mask_done <= 1'b1; mask_err <= 1'b1;
    end else begin
      if (done_test)                   tdone <= 1'b1;
      else if (clr_int_ok || clr_err)  tdone <= 1'b0;
      if (done_seed)                   sdone <= 1'b1;
      else if (clr_int_ok || clr_err)  sdone <= 1'b0;
      err <= (clr_err ? 4'h0 : err)
             | (4'(stat_fail) << ERR_STAT) | (4'(under) << ERR_UNDER);
      if (seed_go)        seeded <= 1'b0;
      else if (done_seed) seeded <= !health_fail;
      if (wr_ctrl) begin
        mask_done <= reg_wdata[CTL_MDONE];
        mask_err  <= reg_wdata[CTL_MERR];
      end
    end
  end

  assign lvl_field = (level > CW'(15)) ? 4'hF : 4'(level);

  always_comb begin
    status = '0;
    status[ST_TDONE] = tdone;
    status[ST_SDONE] = sdone;
    status[ST_LVL_LO +: 4] = lvl_field;
    status[ST_ERR] = (err != '0);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: begin
          reg_rdata[CTL_MDONE] = mask_done;
          reg_rdata[CTL_MERR]  = mask_err;
        end
        OFS_STAT: reg_rdata = status;
        OFS_ERR:  reg_rdata = {28'h0, err};
        OFS_FIFO: reg_rdata = (level != '0) ? fifo_head : 32'h0;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign irq = ((tdone || sdone) && !mask_done) || ((err != '0) && !mask_err);

  assert_clrint_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && reg_wdata[CMD_CLRINT] && !reg_wdata[CMD_CLRERR] && err != '0 && sdone)
      |=> sdone);
  assert_clrerr_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !done_seed && !rd_fifo) |=> (err == '0 && !tdone && !sdone));
  assert_stat_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fail |=> (err[ERR_STAT] && !seeded));
  assert_full_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH)) |-> (status[ST_LVL_LO +: 4] == 4'hF));
  assert_health_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_seed && !under && !clr_err) |=> (err == $past(err)));
endmodule

// File: tb/rng_ctrl_regs_test.sv
module rng_ctrl_regs_test;
  localparam int OPC = 8;
  localparam int DEP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, health_fail = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] mdl = 32'h2545F491;

  rng_ctrl_regs #(.OP_CYCLES(OPC), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .health_fail(health_fail), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] gen(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] ctl);
    return ((st[4] || st[5]) && !ctl[5]) || (st[16] && !ctl[6]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fifo_word(input string req);
    logic [31:0] d;
    rd(8'h14, d);
    mdl = gen(mdl);
    chk(req, d, mdl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ctl;
    void'($urandom(32'h5EED1234));
    idle(3); rst_n = 1; idle(2);

    // reset state
    rd(8'h0C, d); chk("R1 status reset", d, 32'h0);
    rd(8'h08, d); chk("R2 control reset", d, 32'h60);
    rd(8'h10, d); chk("R1 error reset", d, 32'h0);
    rd(8'h04, d); chk("R1 command reads zero", d, 32'h0);
    rd(8'h00, d); chk("R1 unmapped read", d, 32'h0);
    chk("R11 irq reset", {31'h0, irq}, 32'h0);

    // empty FIFO read before any seed
    rd(8'h14, d); chk("R8 empty read data", d, 32'h0);
    rd(8'h10, d); chk("R8 underflow code", d, 32'h1);
    rd(8'h0C, d); chk("R8 error status bit", d, 32'h10000);
    wr(8'h04, 32'h10);
    rd(8'h10, d); chk("R9 clear-int keeps error", d, 32'h1);
    wr(8'h04, 32'h20);
    rd(8'h0C, d); chk("R10 clear-error status", d, 32'h0);

    // self-test, with a seed request while busy
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R2 control write", d, 32'h0);
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h2);
    idle(OPC + 4);
    rd(8'h0C, d); chk("R3 R5 self-test done only", d, 32'h10);
    chk("R11 irq on done", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h20);
    chk("R11 done masked", {31'h0, irq}, 32'h0);
    wr(8'h04, 32'h10);
    rd(8'h0C, d); chk("R9 clear-int clean", d, 32'h0);

    // health pulse while idle is ignored
    health_fail = 1; idle(2); health_fail = 0;
    rd(8'h10, d); chk("R12 idle health ignored", d, 32'h0);

    // seed with statistical failure
    health_fail = 1;
    wr(8'h04, 32'h2);
    idle(OPC + 4);
    health_fail = 0;
    rd(8'h10, d); chk("R6 stat code", d, 32'h8);
    rd(8'h0C, d); chk("R6 status no refill", d, 32'h10020);
    chk("R11 error irq", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h60);
    chk("R11 both masked", {31'h0, irq}, 32'h0);
    wr(8'h04, 32'h10);
    rd(8'h0C, d); chk("R9 clear-int blocked", d, 32'h10020);
    wr(8'h04, 32'h20);
    rd(8'h0C, d); chk("R10 clear-error all", d, 32'h0);

    // clean seed, both start bits
    wr(8'h04, 32'h3);
    idle(OPC + DEP + 6);
    rd(8'h0C, d); chk("R4 R7 seed done full", d, 32'h0F20);
    fifo_word("R7 first word");

    // random mix
    ctl = 32'h60;
    for (int i = 0; i < 60; i++) begin
      idle($urandom % 4);
      case ($urandom % 4)
        0, 1: fifo_word("R8 fifo order");
        2: begin
          ctl = $urandom & 32'h60;
          wr(8'h08, $urandom);
          rd(8'h08, d); ctl = d;
          rd(8'h0C, d);
          chk("R11 irq vs mask", {31'h0, irq}, {31'h0, exp_irq(d, ctl)});
        end
        default: begin
          wr(8'h18 + 8'(($urandom % 8) * 4), $urandom);
          rd(8'h10, d); chk("R1 unmapped write", d, 32'h0);
        end
      endcase
    end

    // failed reseed, then drain to empty
    wr(8'h08, 32'h60);
    idle(3);
    health_fail = 1;
    wr(8'h04, 32'h2);
    idle(OPC + 4);
    health_fail = 0;
    rd(8'h0C, d); chk("R6 R7 full after failed seed", d, 32'h10F20);
    for (int i = 0; i < DEP; i++) fifo_word("R8 drain");
    rd(8'h0C, d); chk("R6 no refill", d, 32'h10020);
    rd(8'h14, d); chk("R8 empty after drain", d, 32'h0);
    rd(8'h10, d); chk("R8 underflow plus stat", d, 32'h9);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule